// File: doc/BRIEF.md
# Start-Pulse Accelerator Handshake Wrapper

This block sits between a simple processor register bus and a fixed-latency hardware function. Software writes an operand to a command register. The wrapper holds the operand and raises a pending flag. On the next clock edge it turns that flag into a one-cycle start pulse, and the same edge drops the flag. The function wakes only on that pulse and works for a fixed number of cycles. When it is done, the wrapper sets a result-ready flag and presents the result.

Software polls a status register until the ready bit shows, then reads the result register, and that read acknowledges the result. The function is a placeholder multiply-add, `result = operand * MUL_K + ADD_K`, kept to the data width. Writes that arrive while an operation is in flight, or while a result waits to be read, are dropped and recorded in a sticky overrun bit.

Top module: `acc_hs_top`

## Requirements
- R1: After synchronous reset every flag is clear: a status read returns 0, and the operand and result registers read as 0.
- R2: A write to address 0 (operand) while the wrapper is idle stores the data, readable back at address 0, and sets the pending bit (status bit 3) on that same clock edge.
- R3: `start_o` goes high on the first edge after the pending bit was set and stays high for exactly one cycle; that edge also clears the pending bit.
- R4: The result-ready bit (status bit 0) rises exactly LATENCY (default 4) clock edges after the edge on which `start_o` rose. The busy bit (status bit 1) is high from the write edge until that point.
- R5: The value read at address 1 (result) equals `(operand * 3 + 1) mod 2^DATA_W` for the operand that started the run.
- R6: A read strobe at address 1 clears the ready bit on that edge. Reading status (address 2) leaves the ready bit set.
- R7: An operand write while pending, starting, running or while a result is unread is ignored: the operand, the result and the start count are unchanged. It sets the overrun bit (status bit 2), which stays set until reset.
- R8: The status word at address 2 is zero-extended, with bit 0 ready, bit 1 busy, bit 2 overrun and bit 3 pending.
- R9: Writes to addresses other than 0 change no state and produce no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 operand, 1 result, 2 status |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe; at address 1 it acknowledges the result |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| start_o | output | 1 | One-cycle start pulse issued to the function |

## Verification
The function is driven with operands 0, all ones, a mid-range value and 0x5555. The last wraps exactly to zero, so these separate correct modular truncation from a lost carry or a stale result. One operation is traced cycle by cycle to pin the pending bit, the single start cycle and the ready edge to the exact cycles. Back-to-back writes, a write while the result is unread, and a write to a non-operand address each show whether a command that should be dropped leaks into the operand latch or fires an extra start. A status read with the read strobe high separates a clear that is tied to the result address from one that fires on any read.

// File: rtl/acc_hs_pkg.sv
package acc_hs_pkg;

    localparam int BUS_ADDR_W = 2;
    localparam int STATUS_W   = 4;

    typedef enum logic [BUS_ADDR_W-1:0] {
        SEL_OPERAND = 2'd0,
        SEL_RESULT  = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    // packed MSB first: pending(3) overrun(2) busy(1) ready(0)
    typedef struct packed {
        logic pending;
        logic overrun;
        logic busy;
        logic ready;
    } status_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

endpackage

// File: rtl/acc_cmd_latch.sv
module acc_cmd_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic              engaged,
    input  logic              pend_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] operand,
    output logic              pending,
    output logic              overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            operand <= '0;
            pending <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (pend_clr) begin
                pending <= 1'b0;
            end
            if (wr_hit) begin
                if (engaged) begin
                    overrun <= 1'b1;
                end else begin
                    operand <= wdata;
                    pending <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/acc_start_gen.sv
module acc_start_gen (
    input  logic clk,
    input  logic rst,
    input  logic pend_i,
    output logic start_o,
    output logic pend_clr_o
);
    // The pulse register and the flag clear share the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            start_o <= 1'b0;
        end else begin
            start_o <= pend_i & ~start_o;
        end
    end

    assign pend_clr_o = pend_i;
endmodule

// File: rtl/acc_engine.sv
module acc_engine #(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 4,
    parameter int MUL_K   = 3,
    parameter int ADD_K   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] result_o,
    output logic              running_o,
    output logic              done_o
);
    import acc_hs_pkg::*;

    localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(LATENCY - 1);
    localparam logic [DATA_W-1:0] K_MUL = DATA_W'(MUL_K);
    localparam logic [DATA_W-1:0] K_ADD = DATA_W'(ADD_K);

    eng_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] calc;

    always_comb begin
        calc = operand_i * K_MUL;
        calc = calc + K_ADD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            cnt      <= '0;
            result_o <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start_i) begin
                        state    <= ENG_RUN;
                        cnt      <= CNT_W'(1);
                        result_o <= calc;
                    end
                end
                ENG_RUN: begin
                    if (cnt == LAST) begin
                        state <= ENG_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign running_o = (state == ENG_RUN);
    assign done_o    = running_o && (cnt == LAST);
endmodule

// File: rtl/acc_result_flag.sv
module acc_result_flag (
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic ack_i,
    output logic ready_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready_o <= 1'b0;
        end else if (done_i) begin
            ready_o <= 1'b1;
        end else if (ack_i) begin
            ready_o <= 1'b0;
        end
    end
endmodule

// File: rtl/acc_hs_top.sv
module acc_hs_top #(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 4,
    parameter int MUL_K   = 3,
    parameter int ADD_K   = 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [acc_hs_pkg::BUS_ADDR_W-1:0] bus_addr,
    input  logic                             bus_wr,
    input  logic                             bus_rd,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic                             start_o
);
    import acc_hs_pkg::*;

    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] result;
    logic pending, overrun, pend_clr;
    logic running, done, ready;
    logic busy, engaged, wr_hit, ack;
    status_t status;

    assign wr_hit  = bus_wr && (bus_addr == SEL_OPERAND);
    assign ack     = bus_rd && (bus_addr == SEL_RESULT);
    assign busy    = pending | start_o | running;
    assign engaged = busy | ready;

    acc_cmd_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .engaged(engaged),
        .pend_clr(pend_clr), .wdata(bus_wdata),
        .operand(operand), .pending(pending), .overrun(overrun)
    );

    acc_start_gen u_start (
        .clk(clk), .rst(rst), .pend_i(pending),
        .start_o(start_o), .pend_clr_o(pend_clr)
    );

    acc_engine #(
        .DATA_W(DATA_W), .LATENCY(LATENCY), .MUL_K(MUL_K), .ADD_K(ADD_K)
    ) u_engine (
        .clk(clk), .rst(rst), .start_i(start_o), .operand_i(operand),
        .result_o(result), .running_o(running), .done_o(done)
    );

    acc_result_flag u_ready (
        .clk(clk), .rst(rst), .done_i(done), .ack_i(ack), .ready_o(ready)
    );

    always_comb begin
        status.pending = pending;
        status.overrun = overrun;
        status.busy    = busy;
        status.ready   = ready;
    end

    always_comb begin
        unique case (bus_addr)
            SEL_OPERAND: bus_rdata = operand;
            SEL_RESULT:  bus_rdata = result;
            SEL_STATUS:  bus_rdata = {{(DATA_W-STATUS_W){1'b0}}, status};
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/acc_hs_chk.sv
module acc_hs_chk #(
    parameter int LATENCY = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       pending,
    input logic       running,
    input logic       ready,
    input logic       overrun,
    input logic       bus_rd,
    input logic [1:0] bus_addr
);
    logic [7:0] since_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_start <= '0;
        end else if (start) begin
            since_start <= 8'd1;
        end else if (since_start != 8'd0 && since_start != 8'hFF) begin
            since_start <= since_start + 8'd1;
        end
    end

    p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    p_pending_to_start_r3: assert property (@(posedge clk) disable iff (rst)
        pending |=> (start && !pending));

    p_ready_latency_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (since_start == 8'(LATENCY)));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (ready && bus_rd && bus_addr == 2'd1) |=> !ready);

    p_ready_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (ready && !(bus_rd && bus_addr == 2'd1)) |=> ready);

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    p_no_start_when_engaged_r7: assert property (@(posedge clk) disable iff (rst)
        (running || ready) |=> !start);
endmodule

bind acc_hs_top acc_hs_chk #(.LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst(rst), .start(start_o), .pending(pending),
    .running(running), .ready(ready), .overrun(overrun),
    .bus_rd(bus_rd), .bus_addr(bus_addr)
);

// File: tb/acc_hs_top_tb.sv
module acc_hs_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          start_o;

    int checks = 0;
    int fails  = 0;
    int start_cnt = 0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_q[$];

    acc_hs_top #(.DATA_W(DW), .LATENCY(4), .MUL_K(3), .ADD_K(1)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .start_o(start_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (!rst && start_o) start_cnt++;

    function automatic logic [DW-1:0] model(input logic [DW-1:0] op);
        int unsigned v;
        v = int'(op) * 3 + 1;
        return v[DW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_ready();
        logic [DW-1:0] s;
        for (int i = 0; i < 20; i++) begin
            peek(2'd2, s);
            if (s[0]) break;
            @(negedge clk);
        end
    endtask

    // driver: issue operand, record expected result
    task automatic drive_op(input logic [DW-1:0] op);
        exp_q.push_back(model(op));
        bus_write(2'd0, op);
    endtask

    // monitor: wait for ready, fetch result, compare with scoreboard head
    task automatic collect(input string req);
        logic [DW-1:0] r, e, s;
        wait_ready();
        bus_read(2'd1, r);
        e = exp_q.pop_front();
        check(r == e, req, int'(r), int'(e));
        peek(2'd2, s);
        check(s[0] == 1'b0, "R6 ready cleared by result read", int'(s[0]), 0);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!finished) begin
                    fails++;
                    checks++;
                    $display("FAIL watchdog: actual timeout expected completion");
                    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        logic [DW-1:0] d;
        int sc;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(2'd2, d); check(d == 0, "R1 status after reset", int'(d), 0);
        peek(2'd1, d); check(d == 0, "R1 result after reset", int'(d), 0);
        peek(2'd0, d); check(d == 0, "R1 operand after reset", int'(d), 0);

        // cycle-exact trace of one operation
        exp_q.push_back(model(16'd5));
        bus_write(2'd0, 16'd5);
        peek(2'd2, d); check(d == 16'hA, "R2 R8 pending+busy after write", int'(d), 16'hA);
        check(start_o == 1'b0, "R3 no start on write edge", int'(start_o), 0);
        peek(2'd0, d); check(d == 16'd5, "R2 operand readback", int'(d), 5);
        @(negedge clk);
        check(start_o == 1'b1, "R3 start one edge after pending", int'(start_o), 1);
        peek(2'd2, d); check(d == 16'h2, "R3 pending cleared, busy", int'(d), 2);
        @(negedge clk);
        check(start_o == 1'b0, "R3 start lasts one cycle", int'(start_o), 0);
        @(negedge clk);
        @(negedge clk);
        peek(2'd2, d); check(d == 16'h2, "R4 not ready before latency", int'(d), 2);
        @(negedge clk);
        peek(2'd2, d); check(d == 16'h1, "R4 ready after four edges, not busy", int'(d), 1);
        bus_read(2'd2, d);
        peek(2'd2, d); check(d[0] == 1'b1, "R6 status read keeps ready", int'(d[0]), 1);
        collect("R5 result of 5");

        // R5 several operands through the scoreboard
        drive_op(16'd0);      collect("R5 result of 0");
        drive_op(16'hFFFF);   collect("R5 result of all ones");
        drive_op(16'd1234);   collect("R5 result of 1234");
        drive_op(16'h5555);   collect("R5 result wraps to 0");

        // R7 write during busy
        sc = start_cnt;
        drive_op(16'd10);
        bus_write(2'd0, 16'd99);
        peek(2'd2, d); check(d[2] == 1'b1, "R7 overrun on busy write", int'(d[2]), 1);
        peek(2'd0, d); check(d == 16'd10, "R7 operand kept on busy write", int'(d), 10);
        wait_ready();
        bus_write(2'd0, 16'd77);
        peek(2'd2, d); check(d == 16'h5, "R7 ready+overrun, no new start", int'(d), 5);
        peek(2'd0, d); check(d == 16'd10, "R7 operand kept while ready", int'(d), 10);
        check(start_cnt == sc + 1, "R7 single start for dropped writes", start_cnt - sc, 1);
        collect("R7 result unaffected by dropped writes");
        drive_op(16'd2);      collect("R7 normal op after overrun");
        peek(2'd2, d); check(d[2] == 1'b1, "R7 overrun sticky", int'(d[2]), 1);

        // R9 writes to other addresses
        sc = start_cnt;
        bus_write(2'd2, 16'hFFFF);
        bus_write(2'd1, 16'h1234);
        bus_write(2'd3, 16'h4321);
        repeat (3) @(negedge clk);
        check(start_cnt == sc, "R9 no start from other addresses", start_cnt - sc, 0);
        peek(2'd2, d); check(d == 16'h4, "R9 status unchanged", int'(d), 4);
        peek(2'd0, d); check(d == 16'd2, "R9 operand unchanged", int'(d), 2);
        peek(2'd1, d); check(d == model(16'd2), "R9 result unchanged", int'(d), int'(model(16'd2)));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule